// File: doc/BRIEF.md
# Audio Codec Link Frame Receiver

This block takes the serial input side of an audio codec link and turns each 256-bit frame into parallel status and sample words. It runs on a system clock. The bit clock, frame sync and serial data arrive as plain inputs that are sampled on that clock. A falling edge of the bit clock samples one data bit. A frame sync that rises at such an edge starts a new frame.

Every frame has a 16-bit tag followed by twelve 20-bit slots. The tag says whether the frame as a whole is valid and which slots carry data. The receiver uses the flags for slots 1 to 4:

- Slot 1 echoes a register address and carries two sample request flags.
- Slot 2 returns register read data for the request made in the previous frame.
- Slots 3 and 4 carry the left and right record samples.

Each field has its own strobe, which pulses when that field is refreshed. A single protocol error output flags two conditions. The first is a sample request seen while variable rate mode is off. The second is a frame sync arriving at the wrong bit count.

Top module: `aclink_frame_rx`

## Requirements
- R1: A frame sync sampled high at a bit clock falling edge, after being low at the previous falling edge, marks bit 0 of the tag. Bits arrive most significant bit first, and a frame is 256 bits long. Slot k (1..12) occupies frame bits 16+20(k-1) to 35+20(k-1), and each slot is sent MSB first.
- R2: When tag bit 15 (frame valid) is 0, no field output changes and no strobe is issued for that frame.
- R3: Tag bits 3, 4, 5 and 6 are the valid flags for slots 1, 2, 3 and 4. Each flag gates its own field and strobe independently of the others. Tag bits 14 to 7 and 2 to 0 have no effect.
- R4: A valid slot 1 loads `reg_addr_o` from slot bits 18:12, `req_left_o` from bit 11 and `req_right_o` from bit 10, and pulses `addr_stb_o`. Slot 1 bit 19 and bits 9:0 have no effect.
- R5: A valid slot 2 loads `reg_data_o` from slot bits 19:4 and pulses `data_stb_o`.
- R6: A valid slot 3 loads `rec_left_o` from bits 19:4 and pulses `left_stb_o`. A valid slot 4 does the same for `rec_right_o` and `right_stb_o`. Slot bits 3:0, and all of slots 5 to 12, have no effect.
- R7: `proto_err_o` pulses for one cycle when a captured slot 1 has either request flag at 1 while `var_rate_en` is 0. It does not pulse for request flags when `var_rate_en` is 1, nor for flags in a slot 1 that was not captured.
- R8: A frame sync rise that arrives while a frame is in progress, before bit 255, pulses `proto_err_o`. Reception then restarts from bit 0 at that point. A frame sync rise right after bit 255 raises no error.
- R9: A synchronous reset clears every output. After reset, and after any frame whose bit 255 is not followed by a frame sync rise, no bits are decoded and no strobe is issued until the next frame sync rise.
- R10: Every strobe lasts one clock cycle, and at most one strobe is high in any cycle. A field output takes its new value in the same cycle its strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_clk | input | 1 | Link bit clock, sampled by clk; data taken on its falling edge |
| frame_sync | input | 1 | Frame sync; a rise marks tag bit 0 |
| sdata_in | input | 1 | Serial input data, MSB first |
| var_rate_en | input | 1 | Variable rate mode enable |
| reg_addr_o | output | 7 | Echoed register address from slot 1 |
| req_left_o | output | 1 | Left sample request flag from slot 1 |
| req_right_o | output | 1 | Right sample request flag from slot 1 |
| addr_stb_o | output | 1 | Slot 1 fields refreshed |
| reg_data_o | output | 16 | Register read data from slot 2 |
| data_stb_o | output | 1 | Slot 2 field refreshed |
| rec_left_o | output | 16 | Left record sample from slot 3 |
| left_stb_o | output | 1 | Slot 3 field refreshed |
| rec_right_o | output | 16 | Right record sample from slot 4 |
| right_stb_o | output | 1 | Slot 4 field refreshed |
| proto_err_o | output | 1 | One-cycle protocol error pulse |

## Verification
The main stimulus is a fully valid frame with distinct values in every field. Its ignored bits are set to ones, and these values are then replaced by a second frame. This separates correct slot boundaries and bit positions from off-by-one shifts and leaking ignored bits.

A frame with the frame valid flag cleared, and a frame whose tag enables only slots 2 and 4 while every ignored tag bit is set, show whether the gating is global and per slot. Request flags are sent with variable rate mode off, with it on, and inside an invalid slot 1, which separates the three error cases.

Truncated frames followed by a new sync, and full frames sent without a sync, exercise the restart and lock-loss rules.

// File: rtl/aclrx_pkg.sv
package aclrx_pkg;

  localparam int TAG_BITS  = 16;
  localparam int SLOT_BITS = 20;
  localparam int SLOTS     = 13;
  localparam int SMP_BITS  = 16;
  localparam int ADR_BITS  = 7;
  localparam int SV_BASE   = 3;

  typedef struct packed {
    logic [ADR_BITS-1:0] addr;
    logic                req_l;
    logic                req_r;
  } stat_addr_t;

  function automatic int frame_len(int tag_w, int slot_w, int n_slots);
    return tag_w + slot_w * (n_slots - 1);
  endfunction

  function automatic int slot_last_bit(int tag_w, int slot_w, int k);
    return tag_w - 1 + slot_w * k;
  endfunction

endpackage

// File: rtl/aclrx_bit_timer.sv
module aclrx_bit_timer #(
  parameter int FRAME_BITS = 256,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_clk,
  input  logic             frame_sync,
  output logic             bit_fall,
  output logic             frame_start,
  output logic             bit_valid,
  output logic [CNT_W-1:0] bit_idx,
  output logic             sync_err,
  output logic             locked,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic             bclk_q;
  logic             fs_q;
  logic             lock_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last     = (cnt_q == LAST);
  assign bit_fall    = bclk_q & ~bit_clk;
  assign frame_start = bit_fall & frame_sync & ~fs_q;
  assign bit_valid   = frame_start | (bit_fall & lock_q & ~at_last);
  assign bit_idx     = frame_start ? '0 : cnt_q + 1'b1;
  assign sync_err    = frame_start & lock_q & ~at_last;
  assign locked      = lock_q;
  assign bit_cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      bclk_q <= bit_clk;
      if (bit_fall) begin
        fs_q <= frame_sync;
        if (frame_start) begin
          cnt_q  <= '0;
          lock_q <= 1'b1;
        end else if (lock_q) begin
          if (at_last) lock_q <= 1'b0;
          else         cnt_q  <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aclrx_slot_shifter.sv
module aclrx_slot_shifter
  import aclrx_pkg::*;
#(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 13,
  parameter int CNT_W   = 8,
  parameter int SL_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic              sdata,
  output logic              slot_done,
  output logic [SL_W-1:0]   slot_num,
  output logic [SLOT_W-1:0] slot_word
);
  logic [SLOT_W-2:0] sr_q;
  logic              hit;

  assign slot_word = {sr_q, sdata};

  always_comb begin
    hit      = 1'b0;
    slot_num = '0;
    for (int k = 0; k < N_SLOTS; k++) begin
      if (int'(bit_idx) == slot_last_bit(TAG_W, SLOT_W, k)) begin
        hit      = 1'b1;
        slot_num = SL_W'(k);
      end
    end
  end

  assign slot_done = bit_valid & hit;

  always_ff @(posedge clk) begin
    if (rst)            sr_q <= '0;
    else if (bit_valid) sr_q <= slot_word[SLOT_W-2:0];
  end
endmodule

// File: rtl/aclrx_field_decoder.sv
module aclrx_field_decoder
  import aclrx_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int SL_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_start,
  input  logic                sync_err,
  input  logic                slot_done,
  input  logic [SL_W-1:0]     slot_num,
  input  logic [SLOT_W-1:0]   slot_word,
  input  logic                var_rate_en,
  output logic                frame_ok,
  output logic [ADR_BITS-1:0] reg_addr,
  output logic                req_left,
  output logic                req_right,
  output logic                addr_stb,
  output logic [SMP_BITS-1:0] reg_data,
  output logic                data_stb,
  output logic [SMP_BITS-1:0] rec_left,
  output logic                left_stb,
  output logic [SMP_BITS-1:0] rec_right,
  output logic                right_stb,
  output logic                proto_err
);
  localparam logic [SL_W-1:0] S_TAG  = SL_W'(0);
  localparam logic [SL_W-1:0] S_STAT = SL_W'(1);
  localparam logic [SL_W-1:0] S_DATA = SL_W'(2);
  localparam logic [SL_W-1:0] S_LEFT = SL_W'(3);
  localparam logic [SL_W-1:0] S_RGHT = SL_W'(4);

  function automatic stat_addr_t f_stat(logic [SLOT_W-1:0] w);
    stat_addr_t s;
    s.addr  = w[SLOT_W-2 -: ADR_BITS];
    s.req_l = w[SLOT_W-2-ADR_BITS];
    s.req_r = w[SLOT_W-3-ADR_BITS];
    return s;
  endfunction

  function automatic logic [SMP_BITS-1:0] f_sample(logic [SLOT_W-1:0] w);
    return w[SLOT_W-1 -: SMP_BITS];
  endfunction

  logic       fv_q;
  logic [3:0] sv_q;
  stat_addr_t st;
  logic       unused_low;

  assign st         = f_stat(slot_word);
  assign unused_low = ^slot_word[2:0];
  assign frame_ok   = fv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fv_q      <= 1'b0;
      sv_q      <= '0;
      reg_addr  <= '0;
      req_left  <= 1'b0;
      req_right <= 1'b0;
      reg_data  <= '0;
      rec_left  <= '0;
      rec_right <= '0;
      addr_stb  <= 1'b0;
      data_stb  <= 1'b0;
      left_stb  <= 1'b0;
      right_stb <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      addr_stb  <= 1'b0;
      data_stb  <= 1'b0;
      left_stb  <= 1'b0;
      right_stb <= 1'b0;
      proto_err <= sync_err;
      if (frame_start) fv_q <= 1'b0;
      if (slot_done) begin
        if (slot_num == S_TAG) begin
          fv_q <= slot_word[TAG_W-1];
          sv_q <= slot_word[SV_BASE +: 4];
        end else if (slot_num == S_STAT) begin
          if (fv_q && sv_q[0]) begin
            reg_addr  <= st.addr;
            req_left  <= st.req_l;
            req_right <= st.req_r;
            addr_stb  <= 1'b1;
            if (!var_rate_en && (st.req_l || st.req_r)) proto_err <= 1'b1;
          end
        end else if (slot_num == S_DATA) begin
          if (fv_q && sv_q[1]) begin
            reg_data <= f_sample(slot_word);
            data_stb <= 1'b1;
          end
        end else if (slot_num == S_LEFT) begin
          if (fv_q && sv_q[2]) begin
            rec_left <= f_sample(slot_word);
            left_stb <= 1'b1;
          end
        end else if (slot_num == S_RGHT) begin
          if (fv_q && sv_q[3]) begin
            rec_right <= f_sample(slot_word);
            right_stb <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/aclink_frame_rx.sv
module aclink_frame_rx
  import aclrx_pkg::*;
#(
  parameter int TAG_W   = TAG_BITS,
  parameter int SLOT_W  = SLOT_BITS,
  parameter int N_SLOTS = SLOTS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_clk,
  input  logic                frame_sync,
  input  logic                sdata_in,
  input  logic                var_rate_en,
  output logic [ADR_BITS-1:0] reg_addr_o,
  output logic                req_left_o,
  output logic                req_right_o,
  output logic                addr_stb_o,
  output logic [SMP_BITS-1:0] reg_data_o,
  output logic                data_stb_o,
  output logic [SMP_BITS-1:0] rec_left_o,
  output logic                left_stb_o,
  output logic [SMP_BITS-1:0] rec_right_o,
  output logic                right_stb_o,
  output logic                proto_err_o
);
  localparam int FRAME_BITS = frame_len(TAG_W, SLOT_W, N_SLOTS);
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int SL_W       = $clog2(N_SLOTS);

  logic              bit_fall;
  logic              frame_start;
  logic              bit_valid;
  logic [CNT_W-1:0]  bit_idx;
  logic              sync_err;
  logic              rx_locked;
  logic [CNT_W-1:0]  bit_cnt;
  logic              slot_done;
  logic [SL_W-1:0]   slot_num;
  logic [SLOT_W-1:0] slot_word;
  logic              frame_ok;

  aclrx_bit_timer #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_timer (
    .clk, .rst, .bit_clk, .frame_sync,
    .bit_fall, .frame_start, .bit_valid, .bit_idx,
    .sync_err, .locked(rx_locked), .bit_cnt
  );

  aclrx_slot_shifter #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS), .CNT_W(CNT_W), .SL_W(SL_W)
  ) u_shift (
    .clk, .rst, .bit_valid, .bit_idx, .sdata(sdata_in),
    .slot_done, .slot_num, .slot_word
  );

  aclrx_field_decoder #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .SL_W(SL_W)) u_dec (
    .clk, .rst, .frame_start, .sync_err, .slot_done, .slot_num, .slot_word,
    .var_rate_en, .frame_ok,
    .reg_addr(reg_addr_o), .req_left(req_left_o), .req_right(req_right_o),
    .addr_stb(addr_stb_o), .reg_data(reg_data_o), .data_stb(data_stb_o),
    .rec_left(rec_left_o), .left_stb(left_stb_o),
    .rec_right(rec_right_o), .right_stb(right_stb_o),
    .proto_err(proto_err_o)
  );
endmodule

// File: rtl/aclink_frame_rx_chk.sv
module aclink_frame_rx_chk #(
  parameter int CNT_W      = 8,
  parameter int FRAME_BITS = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             var_rate_en,
  input logic             frame_start,
  input logic             rx_locked,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             addr_stb_o,
  input logic             data_stb_o,
  input logic             left_stb_o,
  input logic             right_stb_o,
  input logic             req_left_o,
  input logic             req_right_o,
  input logic [15:0]      reg_data_o,
  input logic [15:0]      rec_left_o,
  input logic [15:0]      rec_right_o,
  input logic             proto_err_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic any_stb;
  assign any_stb = addr_stb_o | data_stb_o | left_stb_o | right_stb_o;

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({addr_stb_o, data_stb_o, left_stb_o, right_stb_o}) <= 1);

  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    any_stb |=> !any_stb);

  // R9
  strobe_locked_chk: assert property (@(posedge clk) disable iff (rst)
    any_stb |-> $past(rx_locked));

  // R8
  early_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && rx_locked && bit_cnt != LAST) |=> proto_err_o);

  // R7
  req_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_stb_o && !$past(var_rate_en) && (req_left_o || req_right_o)) |-> proto_err_o);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !data_stb_o |-> $stable(reg_data_o));

  // R6
  left_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !left_stb_o |-> $stable(rec_left_o));

  // R6
  right_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !right_stb_o |-> $stable(rec_right_o));
endmodule

bind aclink_frame_rx aclink_frame_rx_chk #(.CNT_W(CNT_W), .FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst(rst), .var_rate_en(var_rate_en),
  .frame_start(frame_start), .rx_locked(rx_locked), .bit_cnt(bit_cnt),
  .addr_stb_o(addr_stb_o), .data_stb_o(data_stb_o),
  .left_stb_o(left_stb_o), .right_stb_o(right_stb_o),
  .req_left_o(req_left_o), .req_right_o(req_right_o),
  .reg_data_o(reg_data_o), .rec_left_o(rec_left_o), .rec_right_o(rec_right_o),
  .proto_err_o(proto_err_o)
);

// File: tb/tb_aclink_frame_rx.sv
`timescale 1ns/1ps
module tb_aclink_frame_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_clk = 1'b0;
  logic frame_sync = 1'b0;
  logic sdata_in = 1'b0;
  logic var_rate_en = 1'b0;
  logic [6:0]  reg_addr_o;
  logic        req_left_o, req_right_o, addr_stb_o;
  logic [15:0] reg_data_o;
  logic        data_stb_o;
  logic [15:0] rec_left_o;
  logic        left_stb_o;
  logic [15:0] rec_right_o;
  logic        right_stb_o;
  logic        proto_err_o;

  aclink_frame_rx dut (
    .clk, .rst, .bit_clk, .frame_sync, .sdata_in, .var_rate_en,
    .reg_addr_o, .req_left_o, .req_right_o, .addr_stb_o,
    .reg_data_o, .data_stb_o, .rec_left_o, .left_stb_o,
    .rec_right_o, .right_stb_o, .proto_err_o
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int n_addr = 0, n_data = 0, n_left = 0, n_right = 0, n_err = 0, n_wide = 0;
  int b_addr, b_data, b_left, b_right, b_err;
  logic [15:0] cap_left = '0;
  logic prev_stb = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (addr_stb_o)  n_addr++;
      if (data_stb_o)  n_data++;
      if (left_stb_o) begin n_left++; cap_left = rec_left_o; end
      if (right_stb_o) n_right++;
      if (proto_err_o) n_err++;
      if (prev_stb && (addr_stb_o | data_stb_o | left_stb_o | right_stb_o)) n_wide++;
      prev_stb = addr_stb_o | data_stb_o | left_stb_o | right_stb_o;
    end else prev_stb = 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_clk = 1'b0; frame_sync = 1'b0; sdata_in = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    b_addr = n_addr; b_data = n_data; b_left = n_left; b_right = n_right; b_err = n_err;
  endtask

  task automatic send_bit(input logic b, input logic s);
    sdata_in = b; frame_sync = s; bit_clk = 1'b1;
    repeat (2) @(negedge clk);
    bit_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [19:0] mk_s1(input logic [6:0] a, input logic rl, input logic rr,
                                        input logic hi, input logic [9:0] lo);
    return {hi, a, rl, rr, lo};
  endfunction

  task automatic send_frame(input logic [15:0] tag, input logic [19:0] s1, input logic [19:0] s2,
                            input logic [19:0] s3, input logic [19:0] s4, input logic [31:0] fill,
                            input int nbits, input logic sync);
    logic [255:0] v;
    v = {tag, s1, s2, s3, s4, {5{fill}}};
    for (int i = 0; i < nbits; i++) send_bit(v[255-i], sync && (i < 16));
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_a();
    send_frame(16'h8078, mk_s1(7'h55, 1'b0, 1'b0, 1'b1, 10'h3FF),
               {16'hBEEF, 4'hF}, {16'h1234, 4'hA}, {16'hFEDC, 4'h5}, 32'hFFFF_FFFF, 256, 1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R9 reset addr", 32'(reg_addr_o), 32'h0);
    check("R9 reset data", 32'(reg_data_o), 32'h0);
    check("R9 reset samples", {rec_left_o, rec_right_o}, 32'h0);
    check("R9 reset strobes/err", {28'h0, addr_stb_o, data_stb_o, left_stb_o | right_stb_o, proto_err_o}, 32'h0);
    send_frame(16'h8078, mk_s1(7'h11, 1'b0, 1'b0, 1'b0, 10'h0),
               {16'h1111, 4'h0}, {16'h2222, 4'h0}, {16'h3333, 4'h0}, 32'h0, 256, 1'b0);
    check("R9 no strobe without sync", 32'((n_addr - b_addr) + (n_data - b_data) + (n_left - b_left) + (n_right - b_right)), 32'h0);
  endtask

  task automatic t_full();
    do_reset();
    var_rate_en = 1'b0;
    frame_a();
    check("R4 addr", 32'(reg_addr_o), 32'h55);
    check("R4 req flags", {30'h0, req_left_o, req_right_o}, 32'h0);
    check("R5 reg data", 32'(reg_data_o), 32'hBEEF);
    check("R6 left", 32'(rec_left_o), 32'h1234);
    check("R6 right", 32'(rec_right_o), 32'hFEDC);
    check("R10 left value at strobe", 32'(cap_left), 32'h1234);
    check("R10 strobe counts", {8'(n_addr - b_addr), 8'(n_data - b_data), 8'(n_left - b_left), 8'(n_right - b_right)}, 32'h01010101);
    check("R8 no error first frame", 32'(n_err - b_err), 32'h0);
    send_frame(16'h8078, mk_s1(7'h2A, 1'b0, 1'b0, 1'b0, 10'h0),
               {16'h0F0F, 4'h0}, {16'h8001, 4'h0}, {16'h7FFE, 4'h0}, 32'h0, 256, 1'b1);
    check("R1 second frame fields", {reg_data_o, rec_left_o}, 32'h0F0F8001);
    check("R1 second frame right/addr", {9'h0, reg_addr_o, rec_right_o}, {9'h0, 7'h2A, 16'h7FFE});
    check("R8 sync after bit 255 no error", 32'(n_err - b_err), 32'h0);
    check("R10 single-cycle strobes", 32'(n_wide), 32'h0);
  endtask

  task automatic t_invalid();
    do_reset();
    frame_a();
    send_frame(16'h0078, mk_s1(7'h01, 1'b0, 1'b0, 1'b0, 10'h0),
               {16'h0002, 4'h0}, {16'h0003, 4'h0}, {16'h0004, 4'h0}, 32'h0, 256, 1'b1);
    check("R2 invalid frame strobes", 32'((n_addr - b_addr) + (n_data - b_data) + (n_left - b_left) + (n_right - b_right)), 32'h4);
    check("R2 invalid frame values kept", {reg_data_o, rec_right_o}, 32'hBEEFFEDC);
    check("R2 invalid frame addr kept", 32'(reg_addr_o), 32'h55);
  endtask

  task automatic t_slotmask();
    do_reset();
    frame_a();
    send_frame(16'hFFD7, mk_s1(7'h01, 1'b0, 1'b0, 1'b0, 10'h0),
               {16'hA5A5, 4'h0}, {16'h5A5A, 4'h0}, {16'hC3C3, 4'h0}, 32'h0, 256, 1'b1);
    check("R3 strobe counts", {8'(n_addr - b_addr), 8'(n_data - b_data), 8'(n_left - b_left), 8'(n_right - b_right)}, 32'h01020102);
    check("R3 slot2/slot4 updated", {reg_data_o, rec_right_o}, 32'hA5A5C3C3);
    check("R3 slot1/slot3 kept", {9'h0, reg_addr_o, rec_left_o}, {9'h0, 7'h55, 16'h1234});
  endtask

  task automatic t_vra();
    do_reset();
    var_rate_en = 1'b0;
    send_frame(16'h8078, mk_s1(7'h10, 1'b1, 1'b0, 1'b0, 10'h0),
               {16'h0, 4'h0}, {16'h0, 4'h0}, {16'h0, 4'h0}, 32'h0, 256, 1'b1);
    check("R7 error on request, rate mode off", 32'(n_err - b_err), 32'h1);
    check("R4 left request flag", {30'h0, req_left_o, req_right_o}, 32'h2);
    send_frame(16'h8070, mk_s1(7'h11, 1'b0, 1'b1, 1'b0, 10'h0),
               {16'h0, 4'h0}, {16'h0, 4'h0}, {16'h0, 4'h0}, 32'h0, 256, 1'b1);
    check("R7 no error for invalid slot 1", 32'(n_err - b_err), 32'h1);
    var_rate_en = 1'b1;
    send_frame(16'h8078, mk_s1(7'h12, 1'b1, 1'b1, 1'b0, 10'h0),
               {16'h0, 4'h0}, {16'h0, 4'h0}, {16'h0, 4'h0}, 32'h0, 256, 1'b1);
    check("R7 no error, rate mode on", 32'(n_err - b_err), 32'h1);
    check("R4 both request flags", {30'h0, req_left_o, req_right_o}, 32'h3);
    var_rate_en = 1'b0;
  endtask

  task automatic t_sync_err();
    do_reset();
    frame_a();
    send_frame(16'h8078, mk_s1(7'h22, 1'b0, 1'b0, 1'b0, 10'h0),
               {16'h2222, 4'h0}, {16'h3333, 4'h0}, {16'h4444, 4'h0}, 32'h0, 100, 1'b1);
    check("R8 no error before early sync", 32'(n_err - b_err), 32'h0);
    send_frame(16'h8078, mk_s1(7'h33, 1'b0, 1'b0, 1'b0, 10'h0),
               {16'h6666, 4'h0}, {16'h7777, 4'h0}, {16'h8888, 4'h0}, 32'h0, 256, 1'b1);
    check("R8 early sync error", 32'(n_err - b_err), 32'h1);
    check("R8 restart decodes new frame", {reg_data_o, rec_right_o}, 32'h66668888);
  endtask

  task automatic t_lost_sync();
    do_reset();
    frame_a();
    send_frame(16'h8078, mk_s1(7'h44, 1'b0, 1'b0, 1'b0, 10'h0),
               {16'h4444, 4'h0}, {16'h4545, 4'h0}, {16'h4646, 4'h0}, 32'h0, 256, 1'b0);
    check("R9 no decode after missing sync", {reg_data_o, rec_left_o}, 32'hBEEF1234);
    send_frame(16'h8078, mk_s1(7'h66, 1'b0, 1'b0, 1'b0, 10'h0),
               {16'h9999, 4'h0}, {16'hAAAA, 4'h0}, {16'hBBBB, 4'h0}, 32'h0, 256, 1'b1);
    check("R9 relock without error", 32'(n_err - b_err), 32'h0);
    check("R9 relock decodes", {reg_data_o, rec_left_o}, 32'h9999AAAA);
  endtask

  initial begin
    t_reset();
    t_full();
    t_invalid();
    t_slotmask();
    t_vra();
    t_sync_err();
    t_lost_sync();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule